// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees a two-wire bus that a slave still holds after a transfer was cut short, with the slave keeping the data line low. When a trigger arrives, the sequencer first waits a bounded time for the controller's busy flag to clear. If the flag stays set through that wait, or the synchronized data line reads low, it takes the clock pin away from the normal controller and toggles it directly. This lets the slave shift out the rest of its byte and let go of the data line.

Clock pulses continue only while the data line stays low, up to a fixed maximum. The sequencer then holds the clock high for one more phase and returns the pins to the controller. It reports completion with a one-cycle done pulse and a failed flag. The data line is only observed, never driven. Issuing a STOP condition afterwards is left to the controller.

Top module: `i2c_bus_clear`

## Requirements
- R1: After reset, `pin_sel` is 0, `scl_drive` is 1, `done` is 0 and `failed` is 0.
- R2: When triggered, the busy flag is polled for up to WAIT_CYC cycles. If busy drops and the synchronized SDA reads 1, the sequencer finishes without taking the pins: `done` pulses, `pin_sel` stays 0 and `failed` is 0.
- R3: Recovery starts if busy is still 1 at the end of the wait, or if the synchronized SDA reads 0 when the wait ends. With busy held, `pin_sel` rises WAIT_CYC+1 cycles after the cycle in which the trigger is applied.
- R4: On entry to recovery, `pin_sel` becomes 1 and `scl_drive` is 0 for the first PHASE_CYC cycles.
- R5: Every phase under direct drive, low or high, lasts exactly PHASE_CYC cycles. Each pulse is one high phase followed by one low phase.
- R6: A new pulse starts only if the synchronized SDA reads 0 at the end of a low phase. The number of pulses therefore equals the number of rising clock edges the slave needs before it releases SDA.
- R7: No more than MAX_PULSES (default 10) pulses are issued per recovery.
- R8: After the last low phase, `scl_drive` is 1 for one PHASE_CYC phase. `pin_sel` then returns to 0 and `done` is 1 for exactly one cycle, in the first cycle with `pin_sel` at 0.
- R9: `failed` is set together with `done` when SDA is still low after the MAX_PULSES-th pulse. Otherwise `failed` is cleared. The flag holds until the next accepted trigger clears it.
- R10: A trigger that arrives while a sequence is in progress is ignored and does not start a second sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Start request, accepted only when idle |
| ctrl_busy | input | 1 | Busy flag from the bus controller |
| sda_in | input | 1 | Raw SDA pin level (asynchronous) |
| scl_drive | output | 1 | Level to drive on SCL while `pin_sel` is 1 |
| pin_sel | output | 1 | 1: sequencer owns SCL; 0: pins belong to the controller |
| done | output | 1 | One-cycle completion pulse |
| failed | output | 1 | SDA still held low after the pulse limit |

## Verification
Two events can coincide at the end of the tenth low phase: the slave releasing SDA, and the pulse cap being reached. Both feed the same exit decision. The bench provokes this with a slave model that lets go of SDA on exactly the tenth rising clock edge, and separately with one that lets go on the fifteenth. The first case must end with ten pulses and `failed` at 0. The second must also end with ten pulses but with `failed` at 1, so the two conditions are told apart by the flag alone, while the pulse count and phase timing stay the same.

// File: rtl/i2cbc_pkg.sv
package i2cbc_pkg;

    typedef enum logic [2:0] {
        BC_IDLE,
        BC_WAIT,
        BC_LEAD_LOW,
        BC_HIGH,
        BC_LOW,
        BC_TAIL_HIGH
    } bc_state_e;

    typedef struct packed {
        logic done;
        logic failed;
    } bc_status_t;

    // True while the sequencer owns the clock pin
    function automatic logic bc_owns_pins(bc_state_e s);
        return (s == BC_LEAD_LOW) || (s == BC_HIGH) ||
               (s == BC_LOW) || (s == BC_TAIL_HIGH);
    endfunction

    // Clock level for a state; idle and wait leave the line released high
    function automatic logic bc_scl_level(bc_state_e s);
        return !((s == BC_LEAD_LOW) || (s == BC_LOW));
    endfunction

endpackage

// File: rtl/bc_sync.sv
module bc_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bc_timer.sv
module bc_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/bc_ctrl.sv
module bc_ctrl
    import i2cbc_pkg::*;
#(
    parameter int MAX_PULSES = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    input  logic       busy,
    input  logic       sda_s,
    input  logic       wait_tick,
    input  logic       ph_tick,
    output bc_state_e  state,
    output logic       state_chg,
    output bc_status_t status
);
    localparam int PCW = $clog2(MAX_PULSES + 1);

    bc_state_e  st_q, st_d;
    logic [PCW-1:0] pulses_q;
    logic       fail_pend_q;
    bc_status_t stat_q;
    logic       more_pulses;

    assign more_pulses = !sda_s && (pulses_q < PCW'(MAX_PULSES));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BC_IDLE:      if (trig) st_d = BC_WAIT;
            BC_WAIT:      if (!busy || wait_tick)
                              st_d = (busy || !sda_s) ? BC_LEAD_LOW : BC_IDLE;
            BC_LEAD_LOW,
            BC_LOW:       if (ph_tick)
                              st_d = more_pulses ? BC_HIGH : BC_TAIL_HIGH;
            BC_HIGH:      if (ph_tick) st_d = BC_LOW;
            BC_TAIL_HIGH: if (ph_tick) st_d = BC_IDLE;
            default:      st_d = BC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= BC_IDLE;
            pulses_q    <= '0;
            fail_pend_q <= 1'b0;
            stat_q      <= '0;
        end else begin
            st_q        <= st_d;
            stat_q.done <= 1'b0;
            if (st_q == BC_WAIT) begin
                pulses_q    <= '0;
                fail_pend_q <= 1'b0;
            end
            if (st_q == BC_HIGH && ph_tick)
                pulses_q <= pulses_q + 1'b1;
            if ((st_q == BC_LEAD_LOW || st_q == BC_LOW) && ph_tick && !more_pulses)
                fail_pend_q <= !sda_s;
            if (st_q == BC_IDLE && trig)
                stat_q.failed <= 1'b0;
            if (st_q == BC_WAIT && st_d == BC_IDLE) begin
                stat_q.done   <= 1'b1;
                stat_q.failed <= 1'b0;
            end
            if (st_q == BC_TAIL_HIGH && st_d == BC_IDLE) begin
                stat_q.done   <= 1'b1;
                stat_q.failed <= fail_pend_q;
            end
        end
    end

    assign state     = st_q;
    assign state_chg = (st_d != st_q);
    assign status    = stat_q;
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
    import i2cbc_pkg::*;
#(
    parameter int unsigned PHASE_CYC  = 50_000,
    parameter int unsigned WAIT_CYC   = 50_000_000,
    parameter int          MAX_PULSES = 10,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic ctrl_busy,
    input  logic sda_in,
    output logic scl_drive,
    output logic pin_sel,
    output logic done,
    output logic failed
);
    logic       sda_s;
    logic       wait_tick, ph_tick, state_chg;
    bc_state_e  state;
    bc_status_t status;

    bc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(sda_in), .q(sda_s)
    );

    bc_timer #(.LIMIT(WAIT_CYC)) u_wait_tmr (
        .clk(clk), .rst(rst), .run(state == BC_WAIT),
        .restart(state_chg), .tick(wait_tick)
    );

    bc_timer #(.LIMIT(PHASE_CYC)) u_phase_tmr (
        .clk(clk), .rst(rst), .run(bc_owns_pins(state)),
        .restart(state_chg), .tick(ph_tick)
    );

    bc_ctrl #(.MAX_PULSES(MAX_PULSES)) u_ctrl (
        .clk(clk), .rst(rst), .trig(trig), .busy(ctrl_busy), .sda_s(sda_s),
        .wait_tick(wait_tick), .ph_tick(ph_tick),
        .state(state), .state_chg(state_chg), .status(status)
    );

    assign pin_sel   = bc_owns_pins(state);
    assign scl_drive = bc_scl_level(state);
    assign done      = status.done;
    assign failed    = status.failed;
endmodule

// File: rtl/i2c_bus_clear_chk.sv
module i2c_bus_clear_chk #(
    parameter int unsigned PHASE_CYC  = 4,
    parameter int          MAX_PULSES = 10
) (
    input logic clk,
    input logic rst,
    input logic scl_drive,
    input logic pin_sel,
    input logic done,
    input logic failed
);
    logic        prev_pin, prev_scl, prev_failed;
    logic [31:0] run_q, rise_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_pin    <= 1'b0;
            prev_scl    <= 1'b1;
            prev_failed <= 1'b0;
            run_q       <= '0;
            rise_q      <= '0;
        end else begin
            prev_pin    <= pin_sel;
            prev_scl    <= scl_drive;
            prev_failed <= failed;
            if (pin_sel && prev_pin && scl_drive == prev_scl) run_q <= run_q + 1;
            else                                              run_q <= 1;
            if (!pin_sel)                                      rise_q <= '0;
            else if (prev_pin && scl_drive && !prev_scl)       rise_q <= rise_q + 1;
        end
    end

    // R4
    lead_low_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_sel && !prev_pin) |-> !scl_drive);

    // R5
    phase_len_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_sel && prev_pin && scl_drive != prev_scl) |-> (run_q == PHASE_CYC));

    // R7
    pulse_cap_chk: assert property (@(posedge clk) disable iff (rst)
        rise_q <= 32'(MAX_PULSES + 1));

    // R8
    handback_high_chk: assert property (@(posedge clk) disable iff (rst)
        (prev_pin && !pin_sel) |-> (prev_scl && done && run_q == PHASE_CYC));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    fail_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        (failed && !prev_failed) |-> done);
endmodule

bind i2c_bus_clear i2c_bus_clear_chk #(
    .PHASE_CYC(PHASE_CYC), .MAX_PULSES(MAX_PULSES)
) u_chk (
    .clk(clk), .rst(rst), .scl_drive(scl_drive), .pin_sel(pin_sel),
    .done(done), .failed(failed)
);

// File: tb/i2c_bus_clear_tb.sv
module i2c_bus_clear_tb;
    localparam int PH   = 4;
    localparam int WT   = 8;
    localparam int MAXP = 10;
    localparam int NV   = 8;

    // busy cycles, slave edges needed, extra trigger, exp recover, exp pulses, exp fail, exp latency
    localparam int V_B [NV] = '{2, 20, 2, 2, 20, 2, 2, 2};
    localparam int V_K [NV] = '{0, 0, 1, 3, 5, 10, 15, 0};
    localparam int V_X [NV] = '{0, 0, 0, 1, 0, 0, 0, 0};
    localparam int V_R [NV] = '{0, 1, 1, 1, 1, 1, 1, 0};
    localparam int V_N [NV] = '{0, 0, 1, 3, 5, 10, 10, 0};
    localparam int V_F [NV] = '{0, 0, 0, 0, 0, 0, 1, 0};
    localparam int V_L [NV] = '{0, WT + 1, 0, 0, WT + 1, 0, 0, 0};

    logic clk = 1'b0;
    logic rst, trig, ctrl_busy, sda_in;
    logic scl_drive, pin_sel, done, failed;
    int   n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    i2c_bus_clear #(.PHASE_CYC(PH), .WAIT_CYC(WT), .MAX_PULSES(MAXP)) u_dut (
        .clk(clk), .rst(rst), .trig(trig), .ctrl_busy(ctrl_busy), .sda_in(sda_in),
        .scl_drive(scl_drive), .pin_sel(pin_sel), .done(done), .failed(failed)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input int b, input int k, input int x, input int er,
                           input int en, input int ef, input int el);
        int  cyc = 0, rises = 0, pins = 0, dones = 0, first_pin = 0, quiet = 0;
        int  fail_at_done = -1;
        bit  pp = 0, ps = 1, finished = 0;
        sda_in = (k == 0);
        repeat (3) @(negedge clk);
        trig = 1'b1;
        ctrl_busy = (b > 0);
        while (!finished) begin
            @(negedge clk);
            cyc++;
            trig = 1'b0;
            ctrl_busy = (cyc < b);
            if (pin_sel && !pp && first_pin == 0) first_pin = cyc;
            if (pin_sel && pp && scl_drive && !ps) rises++;
            pins += int'(pin_sel);
            if (done) begin
                dones++;
                fail_at_done = int'(failed);
            end
            if (dones > 0 && !done) begin
                quiet++;
                if (pin_sel) quiet = 1000;
            end
            sda_in = !(k > 0 && rises < k);
            if (x != 0 && pin_sel && pins == 10) trig = 1'b1;
            pp = pin_sel;
            ps = scl_drive;
            if (quiet >= 20 || cyc > 3000) finished = 1;
        end
        // R6 R7
        chk(rises == (er ? en + 1 : 0), "R6/R7 pulse count", rises, er ? en + 1 : 0);
        // R2 R4 R5 R8
        chk(pins == (er ? PH * (2 * en + 2) : 0), "R5 owned cycles", pins,
            er ? PH * (2 * en + 2) : 0);
        // R8
        chk(dones == 1, "R8 done pulses", dones, 1);
        // R9
        chk(fail_at_done == ef, "R9 failed at done", fail_at_done, ef);
        // R10
        chk(quiet == 20, "R10 no second sequence", quiet, 20);
        // R3
        if (el != 0) chk(first_pin == el, "R3 wait latency", first_pin, el);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; trig = 1'b0; ctrl_busy = 1'b0; sda_in = 1'b1;
        repeat (4) @(negedge clk);
        // R1
        chk(pin_sel == 1'b0, "R1 pin_sel", int'(pin_sel), 0);
        chk(scl_drive == 1'b1, "R1 scl_drive", int'(scl_drive), 1);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(failed == 1'b0, "R1 failed", int'(failed), 0);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            if (i == NV - 1) begin
                // R9: failed held while idle until the next trigger
                repeat (5) @(negedge clk);
                chk(failed == 1'b1, "R9 failed held", int'(failed), 1);
            end
            run_vec(V_B[i], V_K[i], V_X[i], V_R[i], V_N[i], V_F[i], V_L[i]);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule